// File: doc/BRIEF.md
# Presettable Cascadable Up Counter

This block is a small up counter whose range is fixed when it is built: decimal (0 to 9) or binary (0 to 2^WIDTH-1, which is 0 to 15 at the default width). An active-low clear forces the count to zero. An active-low preset copies a parallel data word into the count. Two active-high enables gate counting. `cnt_en` is a plain count enable. `chain_en` also gates the carry output. A build option chooses whether clear acts on the clock edge or at once.

Wider counters are built by chaining stages. Every stage shares `cnt_en`, and each stage's `chain_en` comes from the `carry_out` of the stage below it. A stage then advances only when every stage below it sits at its maximum. All state bits change together on the rising clock edge.

The block has no data stream, so it has no valid/ready handshake. All pins are plain control or status signals, with no back-pressure.

Top module: `chain_counter`

## Requirements
- R1: When clear is inactive, `preset_n` is 1 and both `cnt_en` and `chain_en` are 1, every bit of `count` updates together on a rising edge to the previous value plus one.
- R2: When clear is inactive and `preset_n` is 0 at a rising edge, `count` takes `preset_d` on that edge, whatever the enables are.
- R3: When clear is inactive, `preset_n` is 1 and either enable is 0, `count` holds its value.
- R4: In decimal mode an enabled count at 9 wraps to 0, so a preset of 7 runs 8, 9, 0, 1. In binary mode an enabled count at 15 wraps to 0, so a preset of 12 runs 13, 14, 15, 0.
- R5: In decimal mode a preset value from 10 to 15 goes to 0 on the next enabled count edge.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `count` is at its maximum (9 decimal, 15 binary). It ignores `cnt_en` and `preset_n`, and it follows `chain_en` within the same cycle.
- R7: With ASYNC_CLEAR=0, `clr_n` at 0 on a rising edge sets `count` to 0 on that edge. Before that edge the count is unchanged.
- R8: With ASYNC_CLEAR=1, `clr_n` at 0 sets `count` to 0 at once, without a clock. After `clr_n` returns to 1, the count stays 0 for SYNC_STAGES (default 2) further rising edges, and enabled counting starts on the edge after those.
- R9: Clear takes priority over preset, and preset takes priority over counting.
- R10: Two stages, with the upper stage's `chain_en` driven by the lower stage's `carry_out`, wrap from 99 to 00 in decimal mode and from 255 to 0 in binary mode. The upper stage carries at 99 or 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous according to ASYNC_CLEAR |
| preset_n | input | 1 | Active-low synchronous parallel preset |
| preset_d | input | WIDTH | Value loaded while preset is active |
| cnt_en | input | 1 | Count enable shared by all chained stages |
| chain_en | input | 1 | Count enable that also gates carry_out |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when chain_en is high and count is at its maximum |

## Verification
The assertions check, on every cycle, the step from one count to the next: increment with wrap, preset capture, hold when an enable is low, and zero after any active clear. They also check that the carry never rises without `chain_en` or away from the maximum count. Some behaviour only the bench scenarios can show: the asynchronous clear acting partway through a cycle, the exact number of edges the counter stays at zero after clear is released, how the carry responds to a change of `chain_en` within a cycle, and the two-stage wraps from 99 and 255.

// File: rtl/chain_counter_pkg.sv
`timescale 1ns/1ps
package chain_counter_pkg;
  // Operation chosen for the coming edge, listed in falling priority.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/chain_counter_clr_sync.sv
`timescale 1ns/1ps
module chain_counter_clr_sync #(
  parameter bit ASYNC_CLEAR = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic run_ok
);
  generate
    if (ASYNC_CLEAR) begin : g_async
      // Clear asserts at once and is released only after SYNC_STAGES edges.
      logic [SYNC_STAGES-1:0] shift_q;
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) shift_q <= '0;
        else        shift_q <= {shift_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign run_ok = shift_q[SYNC_STAGES-1];
    end else begin : g_sync
      assign run_ok = clr_n;
    end
  endgenerate
endmodule

// File: rtl/chain_counter_op_sel.sv
`timescale 1ns/1ps
module chain_counter_op_sel
  import chain_counter_pkg::*;
(
  input  logic    run_ok,
  input  logic    preset_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output ctr_op_e op
);
  always_comb begin
    if (!run_ok)                op = OP_CLEAR;
    else if (!preset_n)         op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_COUNT;
    else                        op = OP_HOLD;
  end
endmodule

// File: rtl/chain_counter_next.sv
`timescale 1ns/1ps
module chain_counter_next
  import chain_counter_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int MODULUS = 16
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = load_val;
      // Any value at or beyond the top wraps to zero, illegal presets included.
      OP_COUNT: nxt = (cur >= TOP) ? '0 : cur + 1'b1;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/chain_counter_carry.sv
`timescale 1ns/1ps
module chain_counter_carry #(
  parameter int WIDTH = 4,
  parameter int MODULUS = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             chain_en,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  assign carry_out = chain_en && (cur == TOP);
endmodule

// File: rtl/chain_counter.sv
`timescale 1ns/1ps
module chain_counter
  import chain_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECIMAL     = 1'b1,
  parameter bit ASYNC_CLEAR = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] preset_d,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam int MODULUS = DECIMAL ? 10 : (1 << WIDTH);

  logic             run_ok;
  ctr_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  chain_counter_clr_sync #(
    .ASYNC_CLEAR(ASYNC_CLEAR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clr_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .run_ok(run_ok)
  );

  chain_counter_op_sel u_op_sel (
    .run_ok  (run_ok),
    .preset_n(preset_n),
    .cnt_en  (cnt_en),
    .chain_en(chain_en),
    .op      (op)
  );

  chain_counter_next #(
    .WIDTH  (WIDTH),
    .MODULUS(MODULUS)
  ) u_next (
    .op      (op),
    .cur     (cnt_q),
    .load_val(preset_d),
    .nxt     (cnt_nxt)
  );

  generate
    if (ASYNC_CLEAR) begin : g_state_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
    end else begin : g_state_sync
      always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
      end
    end
  endgenerate

  chain_counter_carry #(
    .WIDTH  (WIDTH),
    .MODULUS(MODULUS)
  ) u_carry (
    .cur      (cnt_q),
    .chain_en (chain_en),
    .carry_out(carry_out)
  );

  assign count = cnt_q;
endmodule

// File: rtl/chain_counter_chk.sv
`timescale 1ns/1ps
module chain_counter_chk #(
  parameter int WIDTH       = 4,
  parameter bit DECIMAL     = 1'b1,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             preset_n,
  input logic [WIDTH-1:0] preset_d,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] count,
  input logic             carry_out,
  input logic             run_ok
);
  localparam int MOD = DECIMAL ? 10 : (1 << WIDTH);
  localparam logic [WIDTH-1:0] TOPV = WIDTH'(MOD - 1);

  function automatic logic [WIDTH-1:0] after_step(input logic [WIDTH-1:0] v);
    return (v >= TOPV) ? '0 : WIDTH'(v + 1'b1);
  endfunction

  // R1, R4, R5: enabled count steps by one and wraps at or past the top
  a_r1_step: assert property (@(posedge clk) disable iff (!clr_n)
    run_ok && preset_n && cnt_en && chain_en |=> count == after_step($past(count)));

  // R2: preset captures the data word
  a_r2_preset: assert property (@(posedge clk) disable iff (!clr_n)
    run_ok && !preset_n |=> count == $past(preset_d));

  // R3: either enable low holds the count
  a_r3_hold: assert property (@(posedge clk) disable iff (!clr_n)
    run_ok && preset_n && !(cnt_en && chain_en) |=> $stable(count));

  // R6: carry needs chain_en and the top count
  a_r6_carry_gate: assert property (@(posedge clk) disable iff (!clr_n)
    !chain_en |-> !carry_out);
  a_r6_carry_top: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> count == TOPV);

  // R7, R9: an active clear wins over preset and count
  a_r9_clear_first: assert property (@(posedge clk)
    !run_ok |=> count == '0);

  generate
    if (ASYNC_CLEAR) begin : g_async_chk
      // R8: the count is already zero while clr_n is low
      a_r8_async_zero: assert property (@(posedge clk)
        !clr_n |-> count == '0);
    end
  endgenerate
endmodule

bind chain_counter chain_counter_chk #(
  .WIDTH      (WIDTH),
  .DECIMAL    (DECIMAL),
  .ASYNC_CLEAR(ASYNC_CLEAR)
) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .preset_n (preset_n),
  .preset_d (preset_d),
  .cnt_en   (cnt_en),
  .chain_en (chain_en),
  .count    (count),
  .carry_out(carry_out),
  .run_ok   (run_ok)
);

// File: tb/chain_counter_bench.sv
`timescale 1ns/1ps
module chain_counter_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_n, preset_n, cnt_en, chain_en;
  logic [3:0] preset_d;
  logic [3:0] dlo, dhi, blo, bhi;
  logic       dlo_c, dhi_c, blo_c, bhi_c;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Decimal chain, synchronous clear
  chain_counter #(.DECIMAL(1'b1), .ASYNC_CLEAR(1'b0)) u_chain_counter (
    .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .preset_d(preset_d),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(dlo), .carry_out(dlo_c));
  chain_counter #(.DECIMAL(1'b1), .ASYNC_CLEAR(1'b0)) u_chain_counter_dhi (
    .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .preset_d(preset_d),
    .cnt_en(cnt_en), .chain_en(dlo_c), .count(dhi), .carry_out(dhi_c));
  // Binary chain, asynchronous clear
  chain_counter #(.DECIMAL(1'b0), .ASYNC_CLEAR(1'b1)) u_chain_counter_blo (
    .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .preset_d(preset_d),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(blo), .carry_out(blo_c));
  chain_counter #(.DECIMAL(1'b0), .ASYNC_CLEAR(1'b1)) u_chain_counter_bhi (
    .clk(clk), .clr_n(clr_n), .preset_n(preset_n), .preset_d(preset_d),
    .cnt_en(cnt_en), .chain_en(blo_c), .count(bhi), .carry_out(bhi_c));

  // Row: {preset_n, preset_d, cnt_en, chain_en, dec count, bin count, dec carry, bin carry}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd7,  1'b1, 1'b1, 4'd7,  4'd7,  1'b0, 1'b0}, // R2 preset 7
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  4'd8,  1'b0, 1'b0}, // R1 R4
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R4 R6 decimal top
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd10, 1'b0, 1'b0}, // R4 decimal wrap
    {1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0, 1'b0}, // R2 preset 12
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd13, 1'b0, 1'b0}, // R5 illegal to 0
    {1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0, 1'b0}, // R2
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd12, 4'd12, 1'b0, 1'b0}, // R3 cnt_en low
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd13, 1'b0, 1'b0}, // R5 R4
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd1,  4'd14, 1'b0, 1'b0}, // R1
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd2,  4'd15, 1'b0, 1'b1}, // R6 binary top
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd2,  4'd15, 1'b0, 1'b1}, // R3 R6 cnt_en ignored by carry
    {1'b1, 4'd0,  1'b1, 1'b0, 4'd2,  4'd15, 1'b0, 1'b0}, // R3 R6 chain_en low
    {1'b0, 4'd9,  1'b0, 1'b0, 4'd9,  4'd9,  1'b0, 1'b0}, // R2 preset without enables
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R3 R6
    {1'b0, 4'd3,  1'b1, 1'b1, 4'd3,  4'd3,  1'b0, 1'b0}, // R9 preset beats count
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd4,  4'd4,  1'b0, 1'b0}  // R1
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0; preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; preset_d = 4'd0;
    @(negedge clk); @(negedge clk);
    check("R7 reset decimal", {dhi, dlo}, 8'd0);
    check("R8 reset binary", {bhi, blo}, 8'd0);
    clr_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {preset_n, preset_d, cnt_en, chain_en} = VEC[i][16:10];
      @(negedge clk);
      check($sformatf("R1-table row %0d decimal count", i), {4'd0, dlo}, {4'd0, VEC[i][9:6]});
      check($sformatf("R1-table row %0d binary count", i), {4'd0, blo}, {4'd0, VEC[i][5:2]});
      check($sformatf("R6 row %0d decimal carry", i), {7'd0, dlo_c}, {7'd0, VEC[i][1]});
      check($sformatf("R6 row %0d binary carry", i), {7'd0, blo_c}, {7'd0, VEC[i][0]});
    end

    // Counts are 4/4. Clear mid-cycle together with preset and enables.
    clr_n = 1'b0; preset_n = 1'b0; preset_d = 4'd5; cnt_en = 1'b1; chain_en = 1'b1;
    #1;
    check("R8 async clear at once", {4'd0, blo}, 8'd0);
    check("R7 sync clear waits for edge", {4'd0, dlo}, 8'd4);
    @(negedge clk);
    check("R7 R9 sync clear beats preset", {dhi, dlo}, 8'd0);
    check("R9 async clear beats preset", {bhi, blo}, 8'd0);

    // Release: the asynchronous stage stays at 0 for two edges
    clr_n = 1'b1; preset_n = 1'b1;
    @(negedge clk);
    check("R8 release edge 1 binary", {4'd0, blo}, 8'd0);
    check("R1 decimal counts after release", {4'd0, dlo}, 8'd1);
    @(negedge clk);
    check("R8 release edge 2 binary", {4'd0, blo}, 8'd0);
    @(negedge clk);
    check("R8 first binary count", {4'd0, blo}, 8'd1);
    check("R1 decimal third count", {4'd0, dlo}, 8'd3);

    // Decimal cascade 99 -> 00
    preset_n = 1'b0; preset_d = 4'd9;
    @(negedge clk);
    check("R10 decimal chain at 99", {dhi, dlo}, 8'h99);
    check("R10 decimal upper carry at 99", {7'd0, dhi_c}, 8'd1);
    preset_n = 1'b1;
    @(negedge clk);
    check("R10 decimal chain wraps", {dhi, dlo}, 8'h00);

    // Binary cascade 255 -> 0
    preset_n = 1'b0; preset_d = 4'd15;
    @(negedge clk);
    check("R10 binary chain at 255", {bhi, blo}, 8'd255);
    check("R10 binary upper carry", {7'd0, bhi_c}, 8'd1);
    preset_n = 1'b1; chain_en = 1'b0;
    #1;
    check("R6 carry falls with chain_en", {7'd0, blo_c}, 8'd0);
    chain_en = 1'b1;
    #1;
    check("R6 carry rises with chain_en", {7'd0, blo_c}, 8'd1);
    @(negedge clk);
    check("R10 binary chain wraps", {bhi, blo}, 8'd0);
    @(negedge clk);
    check("R10 upper stage holds", {bhi, blo}, 8'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule